// File: doc/BRIEF.md
# DDR Write-to-Read Turnaround Gate

This block sits between a DDR SDRAM controller's command scheduler and the memory command bus. Each cycle the scheduler may present one column command (write, read or no-op) with a device select, bank, column and an auto-precharge flag. The gate passes the command to the bus in the same cycle when the turnaround rule permits. When it does not, the gate puts a no-op on the bus and holds the requester off with a ready/valid handshake.

Every write carries a burst of four data beats. They are driven as two double-rate pairs on the two clocks after the command. A later read to the same device must wait a programmable number of clocks. That wait is counted from the first rising edge after the last write pair. A read to a different device is not held back. Each device has its own small down-counter, and a newer write to a device restarts that device's counter. The gate also raises a write-beat strobe while write data is on the bus. It raises a read-valid window for the two clocks in which read data returns, which begin CAS latency clocks after the read.

Top module: `wtr_gate`

## Requirements
- R1: During reset the bus shows no-op, `wr_beat` and `rd_valid` are low and `req_ready` is low. The first read to any device after reset is accepted at once.
- R2: Encodings are 00 no-op, 01 write and 10 read. An issued command appears on `cmd_op` in the cycle it is accepted, with `cmd_dev` and `cmd_bank` copied from the request. `cmd_addr[COL_W-1:0]` holds the column, `cmd_addr[10]` holds the auto-precharge flag, and all other bits are zero. When no command is issued, all of these fields are zero.
- R3: After a write to device d in cycle w, a read to d is refused in cycles w+1 through w+2+T_WTR and is accepted in cycle w+3+T_WTR.
- R4: While a read is refused, `req_ready` is low and `cmd_op` shows no-op.
- R5: A read to a device other than the one last written is accepted as soon as it is presented, including in the cycle right after the write.
- R6: Turnaround is tracked per device. A second write to a device restarts its wait from the newer write, and a write to another device leaves it unchanged.
- R7: `wr_beat` is high in cycles w+1 and w+2 for each write issued in cycle w, and low otherwise.
- R8: `rd_valid` is high in cycles r+CAS_LAT and r+CAS_LAT+1 for each read issued in cycle r, and low otherwise.
- R9: No-op, write and code 11 requests always see `req_ready` high. Code 11 is treated as a no-op.
- R10: With `req_valid` low, nothing is issued and no tracking state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 2 | Requested command code |
| req_dev | input | DEV_W | Target device |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Start column |
| req_ap | input | 1 | Auto-precharge request |
| req_ready | output | 1 | Request can be taken this cycle |
| cmd_op | output | 2 | Command driven to memory |
| cmd_dev | output | DEV_W | Device of issued command |
| cmd_bank | output | BANK_W | Bank of issued command |
| cmd_addr | output | ADDR_W | Address bus, column plus precharge bit |
| wr_beat | output | 1 | Write data on the bus this cycle |
| rd_valid | output | 1 | Read data returning this cycle |

## Verification
The write-beat strobe and the read-valid window can be high in the same cycle. This happens when a write to one device follows a read to another with the right spacing. The bench provokes it by issuing a read and then, on the next cycle, a write to the other device. With CAS latency 2, both strobes are then high in the two cycles that follow the write. Every cycle, each strobe is compared against a model built from the logged issue cycles, so the overlap is judged strobe by strobe. The bench also checks that each strobe drops after its own burst.

// File: rtl/wtr_gate.sv
module wtr_gate #(
  parameter int NDEV    = 2,
  parameter int DEV_W   = (NDEV > 1) ? $clog2(NDEV) : 1,
  parameter int BANK_W  = 2,
  parameter int COL_W   = 10,
  parameter int ADDR_W  = 13,
  parameter int T_WTR   = 1,
  parameter int CAS_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_ap,
  output logic              req_ready,
  output logic [1:0]        cmd_op,
  output logic [DEV_W-1:0]  cmd_dev,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wr_beat,
  output logic              rd_valid
);
  localparam logic [1:0] OP_NOP = 2'b00;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_RD  = 2'b10;
  localparam int HOLD   = 2 + T_WTR;
  localparam int CW     = $clog2(HOLD + 1);
  localparam int AP_BIT = 10;

  logic [CW-1:0]    hold_q [NDEV];
  logic [NDEV-1:0]  dev_clear;
  logic             is_rd, is_wr, go, wr_go, rd_go;
  logic [1:0]       wr_sh;
  logic [CAS_LAT:0] rd_sh;

  assign is_rd     = (req_cmd == OP_RD);
  assign is_wr     = (req_cmd == OP_WR);
  assign req_ready = rst_n && (!is_rd || dev_clear[req_dev]);
  assign go        = req_valid && req_ready && (is_rd || is_wr);
  assign wr_go     = go && is_wr;
  assign rd_go     = go && is_rd;

  assign cmd_op   = go ? req_cmd  : OP_NOP;
  assign cmd_dev  = go ? req_dev  : '0;
  assign cmd_bank = go ? req_bank : '0;

  always_comb begin
    cmd_addr = '0;
    if (go) begin
      cmd_addr[COL_W-1:0] = req_col;
      cmd_addr[AP_BIT]    = req_ap;
    end
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    assign dev_clear[d] = (hold_q[d] == '0);
    always_ff @(posedge clk) begin
      if (!rst_n)
        hold_q[d] <= '0;
      else if (wr_go && req_dev == DEV_W'(d))
        hold_q[d] <= CW'(HOLD);
      else if (hold_q[d] != '0)
        hold_q[d] <= hold_q[d] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_sh <= '0;
      rd_sh <= '0;
    end else begin
      wr_sh <= {wr_sh[0], wr_go};
      rd_sh <= {rd_sh[CAS_LAT-1:0], rd_go};
    end
  end

  assign wr_beat  = |wr_sh;
  assign rd_valid = rd_sh[CAS_LAT-1] | rd_sh[CAS_LAT];

  // R3
  same_dev_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_op) == OP_WR && cmd_op == OP_RD) |-> (cmd_dev != $past(cmd_dev)));

  // R4
  blocked_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_rd && !req_ready) |-> (cmd_op == OP_NOP));

  // R7
  wr_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_op) == OP_WR || $past(cmd_op, 2) == OP_WR) |-> wr_beat);

  // R8
  rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_op, CAS_LAT) == OP_RD) |-> rd_valid);

  // R9
  nonread_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_cmd != OP_RD) |-> req_ready);
endmodule

// File: tb/wtr_gate_tb.sv
module wtr_gate_tb;
  localparam int T_WTR = 1;
  localparam int CL    = 2;
  localparam int TURN  = 3 + T_WTR;
  localparam logic [1:0] NOP = 2'b00, WR = 2'b01, RD = 2'b10, RSV = 2'b11;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ap = 0, req_ready;
  logic [1:0] req_cmd = NOP, cmd_op;
  logic req_dev = 0, cmd_dev;
  logic [1:0] req_bank = 0, cmd_bank;
  logic [9:0] req_col = 0;
  logic [12:0] cmd_addr;
  logic wr_beat, rd_valid;

  wtr_gate #(.NDEV(2), .DEV_W(1), .BANK_W(2), .COL_W(10), .ADDR_W(13),
             .T_WTR(T_WTR), .CAS_LAT(CL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_dev(req_dev), .req_bank(req_bank), .req_col(req_col), .req_ap(req_ap),
    .req_ready(req_ready), .cmd_op(cmd_op), .cmd_dev(cmd_dev), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .wr_beat(wr_beat), .rd_valid(rd_valid));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 10;
  int lw [2] = '{-100, -100};
  bit wh [4096];
  bit rh [4096];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] c, input logic d,
                      input logic [1:0] b, input logic [9:0] col, input logic ap);
    bit rdy_e, iss_e;
    int addr_e;
    @(negedge clk);
    cyc++;
    req_valid = v; req_cmd = c; req_dev = d; req_bank = b; req_col = col; req_ap = ap;
    #1;
    rdy_e = (c != RD) || (cyc >= lw[d] + TURN);
    iss_e = v && rdy_e && (c == WR || c == RD);
    addr_e = iss_e ? ((int'(ap) << 10) | int'(col)) : 0;
    chk(req_ready == rdy_e, (c == RD) ? "R3 ready" : "R9 ready", req_ready, rdy_e);
    if (!v) chk(cmd_op == NOP, "R10 no issue", cmd_op, NOP);
    else if (c == RD && !rdy_e) chk(cmd_op == NOP, "R4 blocked nop", cmd_op, NOP);
    else chk(cmd_op == (iss_e ? c : NOP), "R2 op", cmd_op, iss_e ? c : NOP);
    chk(int'(cmd_addr) == addr_e, "R2 addr", cmd_addr, addr_e);
    chk(cmd_dev == (iss_e ? d : 1'b0) && cmd_bank == (iss_e ? b : 2'b0), "R2 dev/bank",
        {cmd_dev, cmd_bank}, iss_e ? {d, b} : 0);
    chk(wr_beat == (wh[cyc-1] | wh[cyc-2]), "R7 wr_beat", wr_beat, wh[cyc-1] | wh[cyc-2]);
    chk(rd_valid == (rh[cyc-CL] | rh[cyc-CL-1]), "R8 rd_valid", rd_valid,
        rh[cyc-CL] | rh[cyc-CL-1]);
    if (iss_e && c == WR) begin wh[cyc] = 1; lw[d] = cyc; end
    if (iss_e && c == RD) rh[cyc] = 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, WR, 0, 0, 0, 0);
  endtask

  task automatic read_until(input logic d, input int exp_cyc, input string tag);
    int got = -1;
    for (int i = 0; i < 40 && got < 0; i++) begin
      step(1, RD, d, 2'd1, 10'h155, 1'b0);
      if (req_ready) got = cyc;
    end
    chk(got == exp_cyc, tag, got, exp_cyc);
  endtask

  initial begin
    int w;
    repeat (3) @(posedge clk);
    #1;
    chk(cmd_op == NOP && !wr_beat && !rd_valid && !req_ready, "R1 reset outputs",
        {cmd_op, wr_beat, rd_valid, req_ready}, 0);
    @(negedge clk); rst_n = 1;
    step(1, RD, 0, 0, 10'h3, 1'b1);
    chk(cmd_op == RD, "R1 dev0 read after reset", cmd_op, RD);
    step(1, RD, 1, 0, 10'h4, 1'b0);
    chk(cmd_op == RD, "R1 dev1 read after reset", cmd_op, RD);
    idle(4);
    for (int wd = 0; wd < 2; wd++)
      for (int rd = 0; rd < 2; rd++)
        for (int gap = 1; gap <= 6; gap++) begin
          step(1, WR, wd[0], 2'(gap), 10'(gap * 37), gap[0]);
          w = cyc;
          idle(gap - 1);
          read_until(rd[0], (wd == rd) ? ((gap > TURN) ? w + gap : w + TURN) : w + gap,
                     (wd == rd) ? "R3 accept cycle" : "R5 accept cycle");
          idle(6);
        end
    step(1, WR, 0, 0, 10'h10, 0);
    step(1, WR, 0, 1, 10'h20, 1);
    w = cyc;
    read_until(0, w + TURN, "R6 restart on newer write");
    idle(6);
    step(1, WR, 0, 0, 10'h11, 0);
    w = cyc;
    step(1, WR, 1, 3, 10'h22, 1);
    read_until(0, w + TURN, "R6 other device write no effect");
    idle(6);
    step(1, RD, 1, 2, 10'h7, 0);
    step(1, WR, 0, 1, 10'h8, 0);
    step(0, NOP, 0, 0, 0, 0);
    chk(wr_beat && rd_valid, "R7 R8 overlap", {wr_beat, rd_valid}, 3);
    step(0, NOP, 0, 0, 0, 0);
    chk(wr_beat && rd_valid, "R7 R8 overlap second", {wr_beat, rd_valid}, 3);
    idle(4);
    step(1, RSV, 0, 3, 10'h3ff, 1);
    chk(cmd_op == NOP && req_ready, "R9 code 11 as nop", {cmd_op, req_ready}, 1);
    step(0, WR, 1, 0, 10'h5, 0);
    step(1, RD, 1, 0, 10'h6, 0);
    chk(cmd_op == RD, "R10 ignored write left no wait", cmd_op, RD);
    idle(4);
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 20000) begin @(posedge clk); n++; end
    if (!done) chk(0, "watchdog", n, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule